// File: doc/BRIEF.md
# Throttled Multi-Cycle Search Sequencer

This block sits in a vault controller and turns one associative-search request into per-bank row-range commands. Each bank has a throttle level. The level selects how many of the table's rows that bank may activate in one cycle. At the highest level a bank covers the whole table in a single cycle. At a lower level the same search is cut into consecutive row slices, one slice per cycle, which caps the search current in that bank. Other traffic does not slow down.

Software sets a row count for the table at allocation time. The block then fills a small lookup table of rows-per-cycle counts, one count per level, from fixed percentages. No division happens while a search runs: each bank simply looks up its count when the search starts. Each bank walks its own row pointer. Each bank ORs its sense results into a hit flag. The search completes when the slowest bank has covered every row.

Top module: `tss_search_seq`

## Requirements
- R1: After reset `busy`, `done` and every `cmd_valid` bit are 0, the table row count is 0, and every bank's level is 7 (full rate).
- R2: While `busy` is 0, a pulse on `alloc_en` stores `alloc_rows` as the table row count and sets the rows-per-cycle count of level l to max(1, ceil(rows * p(l) / 100)), with p = 10, 22, 35, 48, 61, 74, 87, 100 for levels 0 to 7; while `busy` is 1, `alloc_en` is ignored.
- R3: `lvl_we` writes the 3-bit `lvl_val` into the level of bank `lvl_bank` at any time; a bank's slice size is taken from its level only when a search starts, so a write during a search affects only later searches.
- R4: `srch_req` sampled high while `busy` is 0 starts a search: `busy` is 1 from the next cycle, and the first command group appears in that same cycle.
- R5: While bank b still has rows left, `cmd_valid[b]` is 1 with low row = pointer and high row = min(pointer + n, rows) - 1, where n is the bank's slice count; the pointer starts at 0 and advances by n each cycle, so the slices are contiguous and never pass the last row.
- R6: A bank at level 7 covers rows 0 to rows-1 in one command, the first cycle of the search.
- R7: A bank that has covered all rows drives `cmd_valid[b]` low. In the cycle after the last command group of all banks, `done` is high for exactly one cycle and `busy` is 0.
- R8: `srch_req` while `busy` is 1 is ignored: the running search, its key and its row ranges are unchanged.
- R9: `hit_vec[b]` is cleared at search start and becomes the OR of `slice_hit[b]` over the cycles in which `cmd_valid[b]` is 1; it holds its value after `done` until the next search starts.
- R10: Bank b's command carries bank id b on `cmd_bank[3b+:3]` and key bits `srch_key[16b+:16]` captured at the start.
- R11: With a table row count of 0, a search stays busy for one cycle with no commands and then raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_we | input | 1 | Level write strobe |
| lvl_bank | input | 3 | Bank whose level is written |
| lvl_val | input | 3 | New level value |
| alloc_en | input | 1 | Table allocation strobe |
| alloc_rows | input | 32 | Table row count |
| srch_req | input | 1 | Search request |
| srch_key | input | 128 | Search key, 16 bits per bank |
| slice_hit | input | 8 | Per-bank match result for the current command |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| hit_vec | output | 8 | Per-bank accumulated hit |
| cmd_valid | output | 8 | Per-bank command valid |
| cmd_bank | output | 24 | Per-bank bank identifier |
| cmd_key | output | 128 | Per-bank key share |
| cmd_row_lo | output | 256 | Per-bank first row of the slice |
| cmd_row_hi | output | 256 | Per-bank last row of the slice |

## Verification
The assertions check on every cycle the local rules of the walk. Each command range is ordered and lies inside the table. Consecutive slices of a bank join without gap. Commands appear only while busy. `done` is a single pulse. A request during a search leaves the captured key untouched. The lookup counts are never zero and never decrease with level. Only the bench's scenarios can show the exact slice sizes that the percentage rule gives, and that a level written mid-search takes effect only in the next search. They also show that an allocation during a search is dropped, and that the hit flags equal the OR of the driven results.

// File: rtl/tss_pkg.sv
package tss_pkg;
    // Percentage of the table row count granted per cycle at a given level:
    // lowest level 10 %, highest level 100 %, evenly stepped in between.
    function automatic int unsigned level_pct(input int unsigned lvl, input int unsigned nlev);
        return 10 + (90 * lvl) / (nlev - 1);
    endfunction
endpackage

// File: rtl/tss_level_table.sv
module tss_level_table #(
    parameter int unsigned NUM_LEVELS = 8,
    parameter int unsigned ROW_W      = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 alloc_en,
    input  logic [ROW_W-1:0]                     alloc_rows,
    output logic [ROW_W-1:0]                     rows_o,
    output logic [NUM_LEVELS-1:0][ROW_W-1:0]     cnt_o
);
    localparam int unsigned PW = ROW_W + 8;

    typedef struct packed {
        logic [ROW_W-1:0]                 rows;
        logic [NUM_LEVELS-1:0][ROW_W-1:0] cnt;
    } tbl_t;

    tbl_t st_d, st_q;

    // Rounded-up share of the row count, never below one row.
    function automatic logic [ROW_W-1:0] scaled(input logic [ROW_W-1:0] r, input int unsigned l);
        logic [PW-1:0] p;
        p = {8'd0, r} * PW'(tss_pkg::level_pct(l, NUM_LEVELS)) + PW'(99);
        p = p / PW'(100);
        if (p == '0) p = PW'(1);
        return p[ROW_W-1:0];
    endfunction

    always_comb begin
        st_d = st_q;
        if (alloc_en) begin
            st_d.rows = alloc_rows;
            for (int l = 0; l < NUM_LEVELS; l++) begin
                st_d.cnt[l] = scaled(alloc_rows, l);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rows <= '0;
            for (int l = 0; l < NUM_LEVELS; l++) st_q.cnt[l] <= ROW_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign rows_o = st_q.rows;
    assign cnt_o  = st_q.cnt;

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_chk
        // R2
        cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[l] != '0);
        if (l + 1 < NUM_LEVELS) begin : g_mono
            // R2
            cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.cnt[l] <= st_q.cnt[l+1]);
        end
    end
endmodule

// File: rtl/tss_bank_lane.sv
module tss_bank_lane #(
    parameter int unsigned ROW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ROW_W-1:0] slice_i,
    input  logic [ROW_W-1:0] rows_i,
    input  logic             hit_i,
    output logic             cmd_valid_o,
    output logic [ROW_W-1:0] cmd_lo_o,
    output logic [ROW_W-1:0] cmd_hi_o,
    output logic             last_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [ROW_W-1:0] ptr;
        logic [ROW_W-1:0] slice;
        logic             active;
        logic             hit;
    } lane_t;

    lane_t       st_d, st_q;
    logic [ROW_W:0] nxt;
    logic        reach;

    always_comb begin
        nxt         = {1'b0, st_q.ptr} + {1'b0, st_q.slice};
        reach       = nxt >= {1'b0, rows_i};
        cmd_valid_o = st_q.active;
        cmd_lo_o    = st_q.ptr;
        cmd_hi_o    = reach ? (rows_i - ROW_W'(1)) : (nxt[ROW_W-1:0] - ROW_W'(1));
        last_o      = !st_q.active || reach;

        st_d = st_q;
        if (start_i) begin
            st_d.ptr    = '0;
            st_d.slice  = slice_i;
            st_d.active = (rows_i != '0);
            st_d.hit    = 1'b0;
        end else if (st_q.active) begin
            st_d.ptr    = reach ? rows_i : nxt[ROW_W-1:0];
            st_d.active = !reach;
            st_d.hit    = st_q.hit | hit_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o = st_q.hit;

    // R5
    range_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> cmd_lo_o <= cmd_hi_o);
    // R5
    range_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> cmd_hi_o < rows_i);
    // R5
    slice_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && $past(cmd_valid_o) && !$past(start_i))
            |-> cmd_lo_o == $past(cmd_hi_o) + ROW_W'(1));
endmodule

// File: rtl/tss_search_seq.sv
module tss_search_seq #(
    parameter int unsigned NUM_BANKS  = 8,
    parameter int unsigned NUM_LEVELS = 8,
    parameter int unsigned KEY_W      = 16,
    parameter int unsigned ROW_W      = 32,
    localparam int unsigned BANK_W    = $clog2(NUM_BANKS),
    localparam int unsigned LVL_W     = $clog2(NUM_LEVELS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         lvl_we,
    input  logic [BANK_W-1:0]            lvl_bank,
    input  logic [LVL_W-1:0]             lvl_val,
    input  logic                         alloc_en,
    input  logic [ROW_W-1:0]             alloc_rows,
    input  logic                         srch_req,
    input  logic [NUM_BANKS*KEY_W-1:0]   srch_key,
    input  logic [NUM_BANKS-1:0]         slice_hit,
    output logic                         busy,
    output logic                         done,
    output logic [NUM_BANKS-1:0]         hit_vec,
    output logic [NUM_BANKS-1:0]         cmd_valid,
    output logic [NUM_BANKS*BANK_W-1:0]  cmd_bank,
    output logic [NUM_BANKS*KEY_W-1:0]   cmd_key,
    output logic [NUM_BANKS*ROW_W-1:0]   cmd_row_lo,
    output logic [NUM_BANKS*ROW_W-1:0]   cmd_row_hi
);
    typedef struct packed {
        logic                              busy;
        logic                              done;
        logic [NUM_BANKS*KEY_W-1:0]        key;
        logic [NUM_BANKS-1:0][LVL_W-1:0]   lvl;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                             start;
    logic [ROW_W-1:0]                 tbl_rows;
    logic [NUM_LEVELS-1:0][ROW_W-1:0] tbl_cnt;
    logic [NUM_BANKS-1:0]             lane_last;

    tss_level_table #(
        .NUM_LEVELS (NUM_LEVELS),
        .ROW_W      (ROW_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en && !ctl_q.busy),
        .alloc_rows (alloc_rows),
        .rows_o     (tbl_rows),
        .cnt_o      (tbl_cnt)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
        tss_bank_lane #(.ROW_W(ROW_W)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_i     (start),
            .slice_i     (tbl_cnt[ctl_q.lvl[b]]),
            .rows_i      (tbl_rows),
            .hit_i       (slice_hit[b]),
            .cmd_valid_o (cmd_valid[b]),
            .cmd_lo_o    (cmd_row_lo[b*ROW_W +: ROW_W]),
            .cmd_hi_o    (cmd_row_hi[b*ROW_W +: ROW_W]),
            .last_o      (lane_last[b]),
            .hit_o       (hit_vec[b])
        );
        assign cmd_bank[b*BANK_W +: BANK_W] = BANK_W'(b);
        assign cmd_key[b*KEY_W +: KEY_W]    = ctl_q.key[b*KEY_W +: KEY_W];
    end

    always_comb begin
        start = srch_req && !ctl_q.busy;
        ctl_d = ctl_q;
        ctl_d.done = 1'b0;
        if (lvl_we) ctl_d.lvl[lvl_bank] = lvl_val;
        if (start) begin
            ctl_d.busy = 1'b1;
            ctl_d.key  = srch_key;
        end else if (ctl_q.busy && (&lane_last)) begin
            ctl_d.busy = 1'b0;
            ctl_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.busy <= 1'b0;
            ctl_q.done <= 1'b0;
            ctl_q.key  <= '0;
            for (int b = 0; b < NUM_BANKS; b++) ctl_q.lvl[b] <= LVL_W'(NUM_LEVELS - 1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy = ctl_q.busy;
    assign done = ctl_q.done;

    // R4
    cmd_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_valid) |-> busy);
    // R4
    busy_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(srch_req));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy) && !busy);
    // R8
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && $past(busy)) |-> $stable(cmd_key));
endmodule

// File: tb/tss_search_seq_test.sv
module tss_search_seq_test;
    localparam int NB = 8;
    localparam int KW = 16;
    localparam int RW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lvl_we = 1'b0;
    logic [2:0]      lvl_bank = '0;
    logic [2:0]      lvl_val = '0;
    logic            alloc_en = 1'b0;
    logic [RW-1:0]   alloc_rows = '0;
    logic            srch_req = 1'b0;
    logic [NB*KW-1:0] srch_key = '0;
    logic [NB-1:0]   slice_hit = '0;
    logic            busy, done;
    logic [NB-1:0]   hit_vec, cmd_valid;
    logic [NB*3-1:0] cmd_bank;
    logic [NB*KW-1:0] cmd_key;
    logic [NB*RW-1:0] cmd_row_lo, cmd_row_hi;

    always #2 clk = ~clk;

    tss_search_seq uut (
        .clk(clk), .rst_n(rst_n), .lvl_we(lvl_we), .lvl_bank(lvl_bank), .lvl_val(lvl_val),
        .alloc_en(alloc_en), .alloc_rows(alloc_rows), .srch_req(srch_req), .srch_key(srch_key),
        .slice_hit(slice_hit), .busy(busy), .done(done), .hit_vec(hit_vec), .cmd_valid(cmd_valid),
        .cmd_bank(cmd_bank), .cmd_key(cmd_key), .cmd_row_lo(cmd_row_lo), .cmd_row_hi(cmd_row_hi)
    );

    int n_chk = 0;
    int n_bad = 0;
    int m_rows = 0;
    int m_lvl[NB];
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int slice_rows(input int rows, input int lvl);
        longint p;
        p = longint'(rows) * longint'(10 + (90 * lvl) / 7);
        p = (p + 99) / 100;
        if (p < 1) p = 1;
        return int'(p);
    endfunction

    task automatic do_alloc(input int rows);
        @(negedge clk);
        alloc_en = 1'b1; alloc_rows = RW'(rows);
        @(negedge clk);
        alloc_en = 1'b0;
        m_rows = rows;
    endtask

    task automatic set_lvl(input int b, input int v);
        @(negedge clk);
        lvl_we = 1'b1; lvl_bank = 3'(b); lvl_val = 3'(v);
        @(negedge clk);
        lvl_we = 1'b0;
        m_lvl[b] = v;
    endtask

    // One full search, checked cycle by cycle; probe injects disturbances in the first busy cycle.
    task automatic do_search(input bit probe);
        int ptr[NB];
        int sl[NB];
        logic [NB*KW-1:0] key;
        logic [NB-1:0] exp_hit;
        logic [NB-1:0] hv;
        bit remaining;
        int cyc;
        key = {$urandom, $urandom, $urandom, $urandom};
        for (int b = 0; b < NB; b++) begin
            ptr[b] = 0;
            sl[b] = slice_rows(m_rows, m_lvl[b]);
        end
        exp_hit = '0;
        @(negedge clk);
        srch_req = 1'b1; srch_key = key;
        @(negedge clk);
        srch_req = 1'b0;
        check(busy === 1'b1, "R4", "busy after request", longint'(busy), 1);
        cyc = 0;
        do begin
            for (int b = 0; b < NB; b++) begin
                bit ev;
                int hi;
                ev = ptr[b] < m_rows;
                hi = (ptr[b] + sl[b] >= m_rows) ? m_rows - 1 : ptr[b] + sl[b] - 1;
                check(cmd_valid[b] === ev, "R7", "cmd_valid", longint'(cmd_valid[b]), longint'(ev));
                if (ev) begin
                    check(cmd_row_lo[b*RW +: RW] == RW'(ptr[b]), "R5", "row_lo",
                          longint'(cmd_row_lo[b*RW +: RW]), ptr[b]);
                    check(cmd_row_hi[b*RW +: RW] == RW'(hi), "R5", "row_hi",
                          longint'(cmd_row_hi[b*RW +: RW]), hi);
                    check(cmd_bank[b*3 +: 3] == 3'(b) && cmd_key[b*KW +: KW] == key[b*KW +: KW],
                          "R10", "bank id/key", longint'(cmd_key[b*KW +: KW]), longint'(key[b*KW +: KW]));
                end
            end
            check(busy === 1'b1 && done === 1'b0, "R7", "busy/done mid search",
                  longint'({busy, done}), 2);
            hv = NB'($urandom);
            slice_hit = hv;
            for (int b = 0; b < NB; b++) begin
                if (ptr[b] < m_rows) begin
                    exp_hit[b] = exp_hit[b] | hv[b];
                    ptr[b] = ptr[b] + sl[b];
                end
            end
            if (probe && cyc == 0) begin
                srch_req = 1'b1; srch_key = ~key;          // R8 ignored while busy
                lvl_we = 1'b1; lvl_bank = 3'd0;            // R3 applies next search
                lvl_val = 3'(($urandom % 7));
                m_lvl[0] = int'(lvl_val);
                alloc_en = 1'b1; alloc_rows = RW'(m_rows + 37); // R2 ignored while busy
            end
            remaining = 0;
            for (int b = 0; b < NB; b++) if (ptr[b] < m_rows) remaining = 1;
            @(negedge clk);
            srch_req = 1'b0; lvl_we = 1'b0; alloc_en = 1'b0;
            cyc++;
        end while (remaining);
        slice_hit = '0;
        check(done === 1'b1, "R7", "done pulse", longint'(done), 1);
        check(busy === 1'b0, "R7", "busy low at done", longint'(busy), 0);
        check(cmd_valid === '0, "R7", "no commands after finish", longint'(cmd_valid), 0);
        check(hit_vec === exp_hit, "R9", "hit_vec", longint'(hit_vec), longint'(exp_hit));
        @(negedge clk);
        check(done === 1'b0, "R7", "done single cycle", longint'(done), 0);
        check(hit_vec === exp_hit, "R9", "hit_vec held", longint'(hit_vec), longint'(exp_hit));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++) m_lvl[b] = 7;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(busy === 1'b0 && done === 1'b0, "R1", "busy/done at reset", longint'({busy, done}), 0);
        check(cmd_valid === '0, "R1", "cmd_valid at reset", longint'(cmd_valid), 0);
        rst_n = 1'b1;
        // R11 search on an unallocated (zero-row) table
        do_search(0);
        // R1/R6 default levels are full rate: single cycle over 100 rows
        do_alloc(100);
        do_search(0);
        // R2 directed: level 0 over 200 rows gives 20-row slices
        do_alloc(200);
        for (int b = 0; b < NB; b++) set_lvl(b, b);
        do_search(0);
        // R2 minimum of one row: one-row table at level 0
        do_alloc(1);
        for (int b = 0; b < NB; b++) set_lvl(b, 0);
        do_search(0);
        // R2 rounding up: 7 rows at level 0 -> 1 row per slice, 7 cycles
        do_alloc(7);
        do_search(1);
        // R3/R8/R2 ignored-while-busy probes followed by verification search
        do_search(0);
        // random mixes
        for (int i = 0; i < 30; i++) begin
            if (i % 3 == 0) do_alloc(int'($urandom % 150));
            for (int b = 0; b < NB; b++) if ($urandom % 2 == 1) set_lvl(b, int'($urandom % 8));
            do_search(i % 4 == 1);
        end
        // R11 again after a real table
        do_alloc(0);
        do_search(1);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule